// File: doc/BRIEF.md
# Transfer Descriptor Post-Step Controller

This block sits behind the data mover of a descriptor-driven transfer engine. Each time one data unit has moved, the engine pulses `stepValid` and presents the live descriptor fields. These are a control byte, the transfer kind, the source addressing mode, the unit size, both addresses, the saved start address of the wrapping area, the unit count, its reload value and a block count. One cycle later the block returns the updated descriptor fields and a set of one-cycle strobes. The strobes tell the engine which addresses to write back, whether to clear the interrupt flag of the requesting source, whether to raise a CPU interrupt, and whether to go straight on to the next linked descriptor.

The control byte holds the settings that pick the behaviour. Bit 7 enables linking and bit 6 selects its condition. Bit 5 picks per-unit or end-of-count interrupts. Bit 4 names the side that wraps: 0 is the destination and 1 is the source. Bits 3:2 give the destination addressing mode. Bits 1:0 are reserved. A pending link takes priority over everything else: it hides the end of the count, keeps the request flag set and keeps the interrupt quiet.

Top module: `desc_step_ctrl`

## Requirements
- R1: The destination addressing mode is control-byte bits 3:2. Modes 00 and 01 leave `newDstAddr` equal to `dstAddr` with `dstWriteEn` low. Mode 10 adds the unit step and mode 11 subtracts it, both modulo 2^32 and with `dstWriteEn` high. The unit step is 1, 2 or 4 for `sizeCode` 00, 01 or 10.
- R2: `sizeCode` 11 gives a unit step of 0. The address is then unchanged, but the write-back enables still follow the mode.
- R3: The source side follows the same rules as R1 and R2, with `srcMode` in place of bits 3:2 and `srcWriteEn` in place of `dstWriteEn`.
- R4: In normal kind (`xferKind` 00, and 11, which is treated the same way), `newUnitCount` is `unitCount`-1 modulo 2^16. The count is complete only when `unitCount` is 1.
- R5: In repeat kind (`xferKind` 01), a step with `unitCount` 1 loads `newUnitCount` from `reloadCount`. That step is the completion of the count. The wrapping side (destination if bit 4 is 0, source if bit 4 is 1) gets `areaStart` with its write enable high, while the other side steps as usual.
- R6: In block kind (`xferKind` 10), a step with `unitCount` 1 reloads the count and restores the wrapping side as in R5, and it also decrements `newBlockCount`. In every other case `newBlockCount` equals `blockCount`. The count is complete only when `unitCount` and `blockCount` are both 1.
- R7: When no link is pending, `cpuIrq` is raised on every step if bit 5 is 1, and only on completion if bit 5 is 0.
- R8: When no link is pending, `clearReqFlag` is high exactly when `cpuIrq` is low.
- R9: If bit 7 is 0, `chainNext` is never raised, whatever bit 6 holds. If bit 7 is 1, `chainNext` is raised on every step when bit 6 is 0, and only on steps with `unitCount` 1 when bit 6 is 1.
- R10: A step that raises `chainNext` raises neither `cpuIrq` nor `clearReqFlag`.
- R11: `outValid` is high in exactly the cycle after a `stepValid` cycle. Every strobe is low whenever `outValid` is low. The data outputs hold their values between steps. After reset, all outputs are zero.
- R12: Control-byte bits 1:0 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stepValid | input | 1 | One data unit has moved; evaluate the descriptor |
| modeByte | input | 8 | Control byte (chain, condition, interrupt, wrap side, destination mode, reserved) |
| xferKind | input | 2 | 00 normal, 01 repeat, 10 block, 11 as normal |
| srcMode | input | 2 | Source addressing mode, same encoding as destination |
| sizeCode | input | 2 | Unit size: 00 byte, 01 half, 10 word, 11 reserved |
| srcAddr | input | 32 | Current source address |
| dstAddr | input | 32 | Current destination address |
| areaStart | input | 32 | Saved start address of the wrapping side |
| unitCount | input | 16 | Units left before completion or wrap |
| reloadCount | input | 16 | Value loaded into the count on wrap |
| blockCount | input | 16 | Blocks left in block kind |
| outValid | output | 1 | Results below belong to the last step |
| newSrcAddr | output | 32 | Updated source address |
| newDstAddr | output | 32 | Updated destination address |
| newUnitCount | output | 16 | Updated unit count |
| newBlockCount | output | 16 | Updated block count |
| srcWriteEn | output | 1 | Write the source address back |
| dstWriteEn | output | 1 | Write the destination address back |
| clearReqFlag | output | 1 | Clear the requesting source's interrupt flag |
| cpuIrq | output | 1 | Raise the CPU interrupt |
| chainNext | output | 1 | Continue with the linked descriptor |

## Verification
The hardest situation to reach is a block-kind step that wraps the count, restores the wrapping address and also ends the last block, while link, interrupt and wrap-side settings vary on top of it. The stimulus sweeps every control-byte value against every kind, unit size and a set of counts that includes 1, 2 and 0. Block counts alternate between 1 and 3, and start addresses sit next to the 32-bit boundary, so wrap, completion, linking and address overflow all occur together in many combinations. Each result is checked against an arithmetic model, and each value with nonzero reserved bits is compared to its twin with those bits cleared.

// File: rtl/desc_step_pkg.sv
package desc_step_pkg;

  // What happens to one address side on a step
  typedef enum logic [1:0] {
    OP_HOLD    = 2'b00,
    OP_INC     = 2'b01,
    OP_DEC     = 2'b10,
    OP_RESTORE = 2'b11
  } side_op_e;

  // Side indices inside the control struct
  localparam int SIDE_DST = 0;
  localparam int SIDE_SRC = 1;
  localparam int NUM_SIDES = 2;

  // Transfer kinds
  localparam logic [1:0] KIND_REPEAT = 2'b01;
  localparam logic [1:0] KIND_BLOCK  = 2'b10;

  // Strobes from control to datapath
  typedef struct packed {
    side_op_e [NUM_SIDES-1:0] sideOp;
    logic [NUM_SIDES-1:0]     wrEn;
    logic                     cntReload;
    logic                     blkDec;
    logic                     clrFlag;
    logic                     cpuIrq;
    logic                     chain;
  } step_ctl_t;

endpackage

// File: rtl/desc_step_control.sv
module desc_step_control
  import desc_step_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [7:2]       modeBits,
  input  logic [1:0]       xferKind,
  input  logic [1:0]       srcMode,
  input  logic [CNT_W-1:0] unitCount,
  input  logic [CNT_W-1:0] blockCount,
  output step_ctl_t        ctl
);

  logic chainEn, chainOnLast, irqEach, wrapIsSrc;
  logic kindRepeat, kindBlock;
  logic lastUnit, lastBlock, areaWrap, countDone, chainNow, irqNow;
  logic [1:0] sideMode [NUM_SIDES];

  assign chainEn     = modeBits[7];
  assign chainOnLast = modeBits[6];
  assign irqEach     = modeBits[5];
  assign wrapIsSrc   = modeBits[4];

  assign sideMode[SIDE_DST] = modeBits[3:2];
  assign sideMode[SIDE_SRC] = srcMode;

  assign kindRepeat = (xferKind == KIND_REPEAT);
  assign kindBlock  = (xferKind == KIND_BLOCK);

  assign lastUnit  = (unitCount == CNT_W'(1));
  assign lastBlock = (blockCount == CNT_W'(1));
  assign areaWrap  = (kindRepeat || kindBlock) && lastUnit;

  // Completion of the whole count; blocks need the last block too
  assign countDone = lastUnit && (!kindBlock || lastBlock);

  // A link outranks completion and interrupt handling
  assign chainNow = chainEn && (!chainOnLast || lastUnit);
  assign irqNow   = !chainNow && (irqEach || countDone);

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    logic isWrapSide;
    assign isWrapSide = (s == SIDE_SRC) ? wrapIsSrc : !wrapIsSrc;

    always_comb begin
      if (areaWrap && isWrapSide) begin
        ctl.sideOp[s] = OP_RESTORE;
        ctl.wrEn[s]   = 1'b1;
      end else if (sideMode[s][1]) begin
        ctl.sideOp[s] = sideMode[s][0] ? OP_DEC : OP_INC;
        ctl.wrEn[s]   = 1'b1;
      end else begin
        ctl.sideOp[s] = OP_HOLD;
        ctl.wrEn[s]   = 1'b0;
      end
    end
  end

  assign ctl.cntReload = areaWrap;
  assign ctl.blkDec    = kindBlock && lastUnit;
  assign ctl.chain     = chainNow;
  assign ctl.cpuIrq    = irqNow;
  assign ctl.clrFlag   = !chainNow && !irqNow;

  // R10: a link leaves the request flag and the interrupt alone
  always_comb begin
    a_chain_silent_r10: assert (!(ctl.chain && (ctl.cpuIrq || ctl.clrFlag)));
  end

endmodule

// File: rtl/desc_step_datapath.sv
module desc_step_datapath
  import desc_step_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stepValid,
  input  step_ctl_t         ctl,
  input  logic [1:0]        sizeCode,
  input  logic [ADDR_W-1:0] srcAddr,
  input  logic [ADDR_W-1:0] dstAddr,
  input  logic [ADDR_W-1:0] areaStart,
  input  logic [CNT_W-1:0]  unitCount,
  input  logic [CNT_W-1:0]  reloadCount,
  input  logic [CNT_W-1:0]  blockCount,
  output logic              outValid,
  output logic [ADDR_W-1:0] newSrcAddr,
  output logic [ADDR_W-1:0] newDstAddr,
  output logic [CNT_W-1:0]  newUnitCount,
  output logic [CNT_W-1:0]  newBlockCount,
  output logic              srcWriteEn,
  output logic              dstWriteEn,
  output logic              clearReqFlag,
  output logic              cpuIrq,
  output logic              chainNext
);

  localparam int MAX_SHIFT = 2;

  logic [ADDR_W-1:0] stepAmt;
  logic [ADDR_W-1:0] addrIn   [NUM_SIDES];
  logic [ADDR_W-1:0] addrNext [NUM_SIDES];
  logic [CNT_W-1:0]  cntNext, blkNext;

  // Unit step; the reserved size code moves nothing
  always_comb begin
    if (sizeCode <= 2'(MAX_SHIFT)) stepAmt = ADDR_W'(1) << sizeCode;
    else                           stepAmt = '0;
  end

  assign addrIn[SIDE_DST] = dstAddr;
  assign addrIn[SIDE_SRC] = srcAddr;

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_addr
    always_comb begin
      unique case (ctl.sideOp[s])
        OP_INC:     addrNext[s] = addrIn[s] + stepAmt;
        OP_DEC:     addrNext[s] = addrIn[s] - stepAmt;
        OP_RESTORE: addrNext[s] = areaStart;
        default:    addrNext[s] = addrIn[s];
      endcase
    end
  end

  assign cntNext = ctl.cntReload ? reloadCount : unitCount - CNT_W'(1);
  assign blkNext = ctl.blkDec ? blockCount - CNT_W'(1) : blockCount;

  // Data results: loaded on a step, held otherwise
  always_ff @(posedge clk) begin
    if (!rstN) begin
      newSrcAddr    <= '0;
      newDstAddr    <= '0;
      newUnitCount  <= '0;
      newBlockCount <= '0;
    end else if (stepValid) begin
      newSrcAddr    <= addrNext[SIDE_SRC];
      newDstAddr    <= addrNext[SIDE_DST];
      newUnitCount  <= cntNext;
      newBlockCount <= blkNext;
    end
  end

  // Strobes: live for exactly one cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid     <= 1'b0;
      srcWriteEn   <= 1'b0;
      dstWriteEn   <= 1'b0;
      clearReqFlag <= 1'b0;
      cpuIrq       <= 1'b0;
      chainNext    <= 1'b0;
    end else begin
      outValid     <= stepValid;
      srcWriteEn   <= stepValid && ctl.wrEn[SIDE_SRC];
      dstWriteEn   <= stepValid && ctl.wrEn[SIDE_DST];
      clearReqFlag <= stepValid && ctl.clrFlag;
      cpuIrq       <= stepValid && ctl.cpuIrq;
      chainNext    <= stepValid && ctl.chain;
    end
  end

  p_valid_follows_r11: assert property (@(posedge clk) disable iff (!rstN)
    stepValid |=> outValid);

  p_no_valid_r11: assert property (@(posedge clk) disable iff (!rstN)
    !stepValid |=> !outValid);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> !(srcWriteEn || dstWriteEn || clearReqFlag || cpuIrq || chainNext));

  p_hold_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    !stepValid |=> ($stable(newDstAddr) && $stable(newSrcAddr) && $stable(newUnitCount)));

  p_one_outcome_r8: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $onehot({clearReqFlag, cpuIrq, chainNext}));

  p_reload_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stepValid && ctl.cntReload) |=> (newUnitCount == $past(reloadCount)));

  p_restore_dst_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stepValid && ctl.sideOp[SIDE_DST] == OP_RESTORE) |=> (newDstAddr == $past(areaStart) && dstWriteEn));

  p_fixed_dst_r1: assert property (@(posedge clk) disable iff (!rstN)
    (stepValid && ctl.sideOp[SIDE_DST] == OP_HOLD) |=> (newDstAddr == $past(dstAddr) && !dstWriteEn));

endmodule

// File: rtl/desc_step_ctrl.sv
module desc_step_ctrl
  import desc_step_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stepValid,
  input  logic [7:0]        modeByte,
  input  logic [1:0]        xferKind,
  input  logic [1:0]        srcMode,
  input  logic [1:0]        sizeCode,
  input  logic [ADDR_W-1:0] srcAddr,
  input  logic [ADDR_W-1:0] dstAddr,
  input  logic [ADDR_W-1:0] areaStart,
  input  logic [CNT_W-1:0]  unitCount,
  input  logic [CNT_W-1:0]  reloadCount,
  input  logic [CNT_W-1:0]  blockCount,
  output logic              outValid,
  output logic [ADDR_W-1:0] newSrcAddr,
  output logic [ADDR_W-1:0] newDstAddr,
  output logic [CNT_W-1:0]  newUnitCount,
  output logic [CNT_W-1:0]  newBlockCount,
  output logic              srcWriteEn,
  output logic              dstWriteEn,
  output logic              clearReqFlag,
  output logic              cpuIrq,
  output logic              chainNext
);

  step_ctl_t stepCtl;
  logic      unusedRsvd;

  // Reserved control bits carry no meaning
  assign unusedRsvd = ^modeByte[1:0];

  desc_step_control #(.CNT_W(CNT_W)) u_control (
    .modeBits   (modeByte[7:2]),
    .xferKind   (xferKind),
    .srcMode    (srcMode),
    .unitCount  (unitCount),
    .blockCount (blockCount),
    .ctl        (stepCtl)
  );

  desc_step_datapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_datapath (
    .clk           (clk),
    .rstN          (rstN),
    .stepValid     (stepValid),
    .ctl           (stepCtl),
    .sizeCode      (sizeCode),
    .srcAddr       (srcAddr),
    .dstAddr       (dstAddr),
    .areaStart     (areaStart),
    .unitCount     (unitCount),
    .reloadCount   (reloadCount),
    .blockCount    (blockCount),
    .outValid      (outValid),
    .newSrcAddr    (newSrcAddr),
    .newDstAddr    (newDstAddr),
    .newUnitCount  (newUnitCount),
    .newBlockCount (newBlockCount),
    .srcWriteEn    (srcWriteEn),
    .dstWriteEn    (dstWriteEn),
    .clearReqFlag  (clearReqFlag),
    .cpuIrq        (cpuIrq),
    .chainNext     (chainNext)
  );

endmodule

// File: tb/desc_step_ctrl_tb.sv
module desc_step_ctrl_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        stepValid = 1'b0;
  logic [7:0]  modeByte = '0;
  logic [1:0]  xferKind = '0;
  logic [1:0]  srcMode = '0;
  logic [1:0]  sizeCode = '0;
  logic [31:0] srcAddr = '0;
  logic [31:0] dstAddr = '0;
  logic [31:0] areaStart = '0;
  logic [15:0] unitCount = '0;
  logic [15:0] reloadCount = '0;
  logic [15:0] blockCount = '0;

  logic        outValid;
  logic [31:0] newSrcAddr, newDstAddr;
  logic [15:0] newUnitCount, newBlockCount;
  logic        srcWriteEn, dstWriteEn, clearReqFlag, cpuIrq, chainNext;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [127:0] twinVec;

  desc_step_ctrl u_dut (
    .clk(clk), .rstN(rstN), .stepValid(stepValid), .modeByte(modeByte),
    .xferKind(xferKind), .srcMode(srcMode), .sizeCode(sizeCode),
    .srcAddr(srcAddr), .dstAddr(dstAddr), .areaStart(areaStart),
    .unitCount(unitCount), .reloadCount(reloadCount), .blockCount(blockCount),
    .outValid(outValid), .newSrcAddr(newSrcAddr), .newDstAddr(newDstAddr),
    .newUnitCount(newUnitCount), .newBlockCount(newBlockCount),
    .srcWriteEn(srcWriteEn), .dstWriteEn(dstWriteEn),
    .clearReqFlag(clearReqFlag), .cpuIrq(cpuIrq), .chainNext(chainNext)
  );

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (mode %02h kind %0d size %0d count %0d)",
               tag, act, exp, modeByte, xferKind, sizeCode, unitCount);
    end
  endtask

  function automatic logic [127:0] outVec();
    return {newSrcAddr, newDstAddr, newUnitCount, newBlockCount,
            srcWriteEn, dstWriteEn, clearReqFlag, cpuIrq, chainNext};
  endfunction

  // Expected address of one side from the requirements
  function automatic logic [32:0] sideModel(input logic [1:0] mode, input logic [31:0] addr,
                                            input logic wrapHere);
    logic [31:0] step;
    step = (sizeCode == 2'b11) ? 32'd0 : (32'd1 << sizeCode);
    if (wrapHere)      return {1'b1, areaStart};
    else if (mode == 2'b10) return {1'b1, addr + step};
    else if (mode == 2'b11) return {1'b1, addr - step};
    else               return {1'b0, addr};
  endfunction

  task automatic runStep();
    logic wrap, last, done, chn, irq, clr;
    logic [32:0] expDst, expSrc;
    logic [15:0] expCnt, expBlk;
    last  = (unitCount == 16'd1);
    wrap  = (xferKind == 2'b01 || xferKind == 2'b10) && last;
    done  = last && (xferKind != 2'b10 || blockCount == 16'd1);
    chn   = modeByte[7] && (!modeByte[6] || last);
    irq   = !chn && (modeByte[5] || done);
    clr   = !chn && !irq;
    expDst = sideModel(modeByte[3:2], dstAddr, wrap && !modeByte[4]);
    expSrc = sideModel(srcMode, srcAddr, wrap && modeByte[4]);
    expCnt = wrap ? reloadCount : unitCount - 16'd1;
    expBlk = (xferKind == 2'b10 && last) ? blockCount - 16'd1 : blockCount;

    stepValid = 1'b1;
    @(negedge clk);
    stepValid = 1'b0;
    check("R11 outValid after step", 128'(outValid), 128'(1));
    check(wrap ? "R5 dst address" : "R1 dst address", 128'(newDstAddr), 128'(expDst[31:0]));
    check("R1 dst write-back", 128'(dstWriteEn), 128'(expDst[32]));
    check(sizeCode == 2'b11 ? "R2 src address" : "R3 src address", 128'(newSrcAddr), 128'(expSrc[31:0]));
    check("R3 src write-back", 128'(srcWriteEn), 128'(expSrc[32]));
    check(xferKind == 2'b01 ? "R5 count" : "R4 count", 128'(newUnitCount), 128'(expCnt));
    check("R6 block count", 128'(newBlockCount), 128'(expBlk));
    check("R9 chainNext", 128'(chainNext), 128'(chn));
    check(chn ? "R10 cpuIrq" : "R7 cpuIrq", 128'(cpuIrq), 128'(irq));
    check(chn ? "R10 clearReqFlag" : "R8 clearReqFlag", 128'(clearReqFlag), 128'(clr));
    if (modeByte[1:0] == 2'b00) twinVec = outVec();
    else check("R12 reserved bits", outVec(), twinVec);

    // Idle cycle: strobes drop, data holds
    @(negedge clk);
    check("R11 idle strobes", 128'({outValid, srcWriteEn, dstWriteEn, clearReqFlag, cpuIrq, chainNext}), 128'(0));
    check("R11 idle hold", 128'({newDstAddr, newSrcAddr}), 128'({expDst[31:0], expSrc[31:0]}));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL R11 watchdog: actual %0d cycles expected fewer than 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset outputs", {outVec(), 1'b0} | 128'(outValid), 128'(0));
    rstN = 1'b1;
    @(negedge clk);
    check("R11 reset idle", 128'({outValid, outVec()}), 128'(0));
    areaStart   = 32'hA000_0040;
    reloadCount = 16'd7;
    for (int k = 0; k < 4; k++) begin
      for (int sz = 0; sz < 4; sz++) begin
        for (int cs = 0; cs < 3; cs++) begin
          for (int m = 0; m < 256; m++) begin
            xferKind   = 2'(k);
            sizeCode   = 2'(sz);
            modeByte   = 8'(m);
            unitCount  = (cs == 0) ? 16'd1 : (cs == 1) ? 16'd2 : 16'd0;
            blockCount = sizeCode[0] ? 16'd1 : 16'd3;
            srcMode    = 2'(modeByte[5:4] ^ 2'(k));
            dstAddr    = sizeCode[1] ? 32'hFFFF_FFFF : 32'h1000_0000 + 32'({modeByte[7:2], 2'b00});
            srcAddr    = xferKind[0] ? 32'h0000_0001 : 32'h8000_0000;
            runStep();
          end
        end
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule